// File: doc/BRIEF.md
# Sparse Coherence Directory Cache

This block keeps sharer information for a distributed shared-memory machine, but only for memory blocks that currently have copies outside their home node. Each entry pairs a block-address tag with a bit vector that has one bit per node. Blocks that only the home node holds take no entry at all, so a small set-associative array can track the working set of a much larger memory.

The protocol engine sends one request per handshake: lookup, add a sharer, remove a sharer, or clear an entry. Each request names a block address, a node and the block's home node. A lookup answers one cycle later with a hit flag and the stored vector. An add that misses in a set whose ways are all occupied cannot drop an entry silently. The block picks a victim by pseudo-LRU and issues an invalidation command that carries the victim's address and its whole sharer vector. New requests are held off until that command is taken. Only then is the victim's way reused for the new block.

Top module: `dir_sparse_cache`

## Requirements
- R1: After reset, req_ready_o is 1, inv_valid_o is 0, resp_valid_o is 0, and every lookup misses.
- R2: A lookup that hits sets resp_valid_o and resp_hit_o in the cycle after acceptance, and resp_vec_o then holds the stored sharer vector. Bit n of the vector stands for node n.
- R3: A lookup that misses gives resp_valid_o=1, resp_hit_o=0 and resp_vec_o all zero.
- R4: Request op codes are 0 lookup, 1 add, 2 remove, 3 clear. An add that hits sets the node's bit and keeps all other bits.
- R5: An add that misses where req_node_i equals req_home_i creates no entry.
- R6: An add that misses for a non-home node, in a set with a free way, creates an entry that holds only that node's bit. The free way used is always the lowest-numbered one. The set index is the low log2(SETS) address bits and the tag is the rest.
- R7: A remove that hits clears the node's bit. When the last bit is cleared, the entry is freed and later lookups miss.
- R8: A clear that hits frees the entry without emitting an invalidation.
- R9: An add that misses for a non-home node in a full set raises inv_valid_o in the next cycle. inv_addr_o and inv_vec_o then hold the victim's block address and vector. The victim comes from 3 tree bits per set, all zero at reset. Bit0 selects the half (0 gives ways 0-1, 1 gives ways 2-3), bit1 selects within ways 0-1 and bit2 within ways 2-3. Every hit request and every install sets the bits on the touched way's path to point away from it.
- R10: While inv_valid_o is 1, req_ready_o is 0 and inv_addr_o and inv_vec_o stay stable. On the cycle inv_ready_i is taken, the new block is installed in the victim way with only the requesting node's bit.
- R11: resp_valid_o pulses only in the cycle after an accepted lookup.
- R12: An emitted invalidation vector is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 2 | 0 lookup, 1 add, 2 remove, 3 clear |
| req_addr_i | input | ADDR_W | Block address |
| req_node_i | input | log2(NODES) | Node being added or removed |
| req_home_i | input | log2(NODES) | Home node of the block |
| resp_valid_o | output | 1 | Lookup result valid |
| resp_hit_o | output | 1 | Lookup found an entry |
| resp_vec_o | output | NODES | Sharer vector, zero on a miss |
| inv_valid_o | output | 1 | Invalidation command pending |
| inv_ready_i | input | 1 | Invalidation command taken |
| inv_addr_o | output | ADDR_W | Victim block address |
| inv_vec_o | output | NODES | Victim sharer vector |

## Verification
A corrupted tag or valid bit shows up on the very next lookup as a wrong hit flag or a wrong vector. A wrong sharer bit leaves its trace in resp_vec_o one cycle after a lookup. A wrong pseudo-LRU state cannot be seen until a set fills. It then appears as the wrong victim address on inv_addr_o in the cycle after the add that overflows the set, so the bench fills one set in a known order, touches a way, and checks the address and vector of the way it expects to be evicted. A victim way overwritten too early shows as a changing inv_vec_o during the stall, or as a wrong hit on the evicted address after the handshake.

// File: rtl/dir_cache_pkg.sv
package dir_cache_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ADD    = 2'd1,
    OP_REMOVE = 2'd2,
    OP_CLEAR  = 2'd3
  } dir_op_e;
endpackage

// File: rtl/dir_tag_match.sv
module dir_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAYS-1:0]            hit_oh_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_oh_o[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_oh_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_oh_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/dir_plru.sv
module dir_plru #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-2:0]  state_i,
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAY_W-1:0] touch_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             full_o,
  output logic [WAYS-2:0]  state_o
);
  logic [WAY_W-1:0] tree_victim;
  logic [WAY_W-1:0] free_way;

  assign full_o = &vld_i;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) free_way = WAY_W'(w);
    end
  end

  if (WAYS == 4) begin : g_tree4
    always_comb begin
      tree_victim = state_i[0] ? {1'b1, state_i[2]} : {1'b0, state_i[1]};
      state_o     = state_i;
      state_o[0]  = ~touch_i[1];
      if (touch_i[1]) state_o[2] = ~touch_i[0];
      else            state_o[1] = ~touch_i[0];
    end
  end else begin : g_tree2
    always_comb begin
      tree_victim = state_i[0];
      state_o     = ~touch_i[0];
    end
  end

  assign victim_o = full_o ? tree_victim : free_way;
endmodule

// File: rtl/dir_sparse_cache.sv
module dir_sparse_cache
  import dir_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NODES  = 64,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  localparam int NODE_W = $clog2(NODES),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [NODE_W-1:0] req_home_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [NODES-1:0]  resp_vec_o,
  output logic              inv_valid_o,
  input  logic              inv_ready_i,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic [NODES-1:0]  inv_vec_o
);
  logic [WAYS-1:0]             vld_q  [SETS];
  logic [WAYS-2:0]             plru_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0][NODES-1:0]  vec_q  [SETS];

  logic [SET_W-1:0]  pend_set_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [NODE_W-1:0] pend_node_q;
  logic [WAY_W-1:0]  pend_way_q;

  dir_op_e          op;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             req_fire, inv_done;
  logic [NODES-1:0] node_oh, pend_oh, vec_rd, rem_vec;

  assign op       = dir_op_e'(req_op_i);
  assign set_idx  = req_addr_i[SET_W-1:0];
  assign req_tag  = req_addr_i[ADDR_W-1:SET_W];
  assign req_ready_o = !inv_valid_o;
  assign req_fire = req_valid_i && req_ready_o;
  assign inv_done = inv_valid_o && inv_ready_i;
  assign node_oh  = NODES'(1) << req_node_i;
  assign pend_oh  = NODES'(1) << pend_node_q;

  logic             hit;
  logic [WAYS-1:0]  hit_oh;
  logic [WAY_W-1:0] hit_way;

  dir_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .vld_i    (vld_q[set_idx]),
    .tags_i   (tag_q[set_idx]),
    .tag_i    (req_tag),
    .hit_o    (hit),
    .hit_oh_o (hit_oh),
    .hit_way_o(hit_way)
  );

  assign vec_rd  = vec_q[set_idx][hit_way];
  assign rem_vec = vec_rd & ~node_oh;

  // replacement state follows the pending set while an eviction waits
  logic [SET_W-1:0] plru_set;
  logic [WAY_W-1:0] victim, touch_way;
  logic             set_full;
  logic [WAYS-2:0]  plru_next;

  assign plru_set = inv_valid_o ? pend_set_q : set_idx;

  dir_plru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_plru (
    .state_i (plru_q[plru_set]),
    .vld_i   (vld_q[plru_set]),
    .touch_i (touch_way),
    .victim_o(victim),
    .full_o  (set_full),
    .state_o (plru_next)
  );

  logic [SET_W-1:0] wr_set;
  logic [WAY_W-1:0] wr_way;
  logic [TAG_W-1:0] wr_tag;
  logic [NODES-1:0] wr_vec;
  logic tag_we, vec_we, vld_set, vld_clr, touch_en, start_evict;

  always_comb begin
    wr_set      = set_idx;
    wr_way      = hit_way;
    wr_tag      = req_tag;
    wr_vec      = vec_rd | node_oh;
    tag_we      = 1'b0;
    vec_we      = 1'b0;
    vld_set     = 1'b0;
    vld_clr     = 1'b0;
    touch_en    = 1'b0;
    touch_way   = hit_way;
    start_evict = 1'b0;
    if (inv_done) begin
      wr_set    = pend_set_q;
      wr_way    = pend_way_q;
      wr_tag    = pend_tag_q;
      wr_vec    = pend_oh;
      tag_we    = 1'b1;
      vec_we    = 1'b1;
      touch_en  = 1'b1;
      touch_way = pend_way_q;
    end else if (req_fire) begin
      unique case (op)
        OP_LOOKUP: touch_en = hit;
        OP_ADD: begin
          if (hit) begin
            vec_we   = 1'b1;
            touch_en = 1'b1;
          end else if (req_node_i != req_home_i) begin
            if (set_full) begin
              start_evict = 1'b1;
            end else begin
              wr_way    = victim;
              wr_vec    = node_oh;
              tag_we    = 1'b1;
              vec_we    = 1'b1;
              vld_set   = 1'b1;
              touch_en  = 1'b1;
              touch_way = victim;
            end
          end
        end
        OP_REMOVE: begin
          if (hit) begin
            wr_vec   = rem_vec;
            vec_we   = 1'b1;
            vld_clr  = (rem_vec == '0);
            touch_en = 1'b1;
          end
        end
        OP_CLEAR: vld_clr = hit;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (tag_we) tag_q[wr_set][wr_way] <= wr_tag;
    if (vec_we) vec_q[wr_set][wr_way] <= wr_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_vec_o   <= '0;
      inv_valid_o  <= 1'b0;
      inv_addr_o   <= '0;
      inv_vec_o    <= '0;
      pend_set_q   <= '0;
      pend_tag_q   <= '0;
      pend_node_q  <= '0;
      pend_way_q   <= '0;
    end else begin
      if (vld_set)  vld_q[wr_set][wr_way] <= 1'b1;
      if (vld_clr)  vld_q[wr_set][wr_way] <= 1'b0;
      if (touch_en) plru_q[wr_set] <= plru_next;
      resp_valid_o <= req_fire && (op == OP_LOOKUP);
      resp_hit_o   <= hit;
      resp_vec_o   <= hit ? vec_rd : '0;
      if (start_evict) begin
        inv_valid_o <= 1'b1;
        inv_addr_o  <= {tag_q[set_idx][victim], set_idx};
        inv_vec_o   <= vec_q[set_idx][victim];
        pend_set_q  <= set_idx;
        pend_tag_q  <= req_tag;
        pend_node_q <= req_node_i;
        pend_way_q  <= victim;
      end else if (inv_done) begin
        inv_valid_o <= 1'b0;
      end
    end
  end

  AST_INV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !inv_ready_i |=> inv_valid_o && $stable(inv_addr_o) && $stable(inv_vec_o)); // R10
  AST_INV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> inv_vec_o != '0); // R12
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_hit_o |-> resp_vec_o == '0); // R3
  AST_RESP_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i && req_ready_o && req_op_i == 2'd0)); // R11
  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_oh)); // R6
  AST_VICTIM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> vld_q[pend_set_q][pend_way_q]); // R10
endmodule

// File: tb/dir_sparse_cache_tb.sv
`timescale 1ns/1ps
module dir_sparse_cache_tb;
  localparam int ADDR_W = 32;
  localparam int NODES  = 64;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [5:0]  node;
    logic [5:0]  home;
    logic        hit;
    logic [63:0] vec;
  } vec_t;

  // set 5: X = tag1 (0x45), Y = tag2 (0x85)
  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b0, 64'h0},                  // R3 miss
    '{2'd1, 32'h45, 6'd3,  6'd0, 1'b0, 64'h0},                  // R6 alloc
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b1, 64'h8},                  // R2
    '{2'd1, 32'h45, 6'd10, 6'd0, 1'b0, 64'h0},                  // R4
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b1, 64'h408},                // R4
    '{2'd1, 32'h45, 6'd0,  6'd0, 1'b0, 64'h0},                  // home add on hit: bit 0 set
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b1, 64'h409},                // R4
    '{2'd1, 32'h85, 6'd7,  6'd7, 1'b0, 64'h0},                  // R5
    '{2'd0, 32'h85, 6'd0,  6'd0, 1'b0, 64'h0},                  // R5
    '{2'd2, 32'h45, 6'd3,  6'd0, 1'b0, 64'h0},                  // R7
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b1, 64'h401},                // R7
    '{2'd2, 32'h45, 6'd10, 6'd0, 1'b0, 64'h0},
    '{2'd2, 32'h45, 6'd0,  6'd0, 1'b0, 64'h0},                  // R7 last bit
    '{2'd0, 32'h45, 6'd0,  6'd0, 1'b0, 64'h0},                  // R7 freed
    '{2'd1, 32'h85, 6'd63, 6'd1, 1'b0, 64'h0},
    '{2'd3, 32'h85, 6'd0,  6'd1, 1'b0, 64'h0},                  // R8
    '{2'd0, 32'h85, 6'd0,  6'd0, 1'b0, 64'h0}                   // R8 freed
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [5:0]        req_node_i = '0;
  logic [5:0]        req_home_i = '0;
  logic              resp_valid_o, resp_hit_o;
  logic [NODES-1:0]  resp_vec_o;
  logic              inv_valid_o;
  logic              inv_ready_i = 1'b0;
  logic [ADDR_W-1:0] inv_addr_o;
  logic [NODES-1:0]  inv_vec_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  dir_sparse_cache u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_node_i, .req_home_i, .resp_valid_o, .resp_hit_o, .resp_vec_o,
    .inv_valid_o, .inv_ready_i, .inv_addr_o, .inv_vec_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr,
                        input logic [5:0] node, input logic [5:0] home);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_addr_i  = addr;
    req_node_i  = node;
    req_home_i  = home;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic look(input logic [31:0] addr, input logic hit, input logic [63:0] vec,
                      input string req);
    do_req(2'd0, addr, 6'd0, 6'd0);
    check({req, " valid"}, 64'(resp_valid_o), 64'd1);
    check({req, " hit"},   64'(resp_hit_o), 64'(hit));
    check({req, " vec"},   resp_vec_o, vec);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ready", 64'(req_ready_o), 64'd1);
    check("R1 inv_valid", 64'(inv_valid_o), 64'd0);
    check("R1 resp_valid", 64'(resp_valid_o), 64'd0);
    look(32'h40, 1'b0, 64'h0, "R1 empty");

    for (int i = 0; i < NV; i++) begin
      do_req(TBL[i].op, TBL[i].addr, TBL[i].node, TBL[i].home);
      check($sformatf("R11 row %0d resp_valid", i), 64'(resp_valid_o), 64'(TBL[i].op == 2'd0));
      if (TBL[i].op == 2'd0) begin
        check($sformatf("R2 row %0d hit", i), 64'(resp_hit_o), 64'(TBL[i].hit));
        check($sformatf("R3 row %0d vec", i), resp_vec_o, TBL[i].vec);
      end
    end

    // fill set 0: A,B,C,D land in ways 0..3 (R6)
    do_req(2'd1, 32'h40,  6'd1, 6'd0);
    do_req(2'd1, 32'h80,  6'd2, 6'd0);
    do_req(2'd1, 32'hC0,  6'd3, 6'd0);
    do_req(2'd1, 32'hC0,  6'd4, 6'd0);
    do_req(2'd1, 32'h100, 6'd6, 6'd0);
    check("R12 no inv on free ways", 64'(inv_valid_o), 64'd0);
    look(32'h40, 1'b1, 64'h2, "R2 A");
    // tree now points at way 2 (C)
    do_req(2'd1, 32'h140, 6'd5, 6'd0);
    check("R9 inv_valid", 64'(inv_valid_o), 64'd1);
    check("R9 inv_addr", 64'(inv_addr_o), 64'hC0);
    check("R12 inv_vec", inv_vec_o, 64'h18);
    check("R10 stall", 64'(req_ready_o), 64'd0);
    repeat (3) @(negedge clk_i);
    check("R10 hold valid", 64'(inv_valid_o), 64'd1);
    check("R10 hold addr", 64'(inv_addr_o), 64'hC0);
    check("R10 hold vec", inv_vec_o, 64'h18);
    inv_ready_i = 1'b1;
    @(negedge clk_i);
    inv_ready_i = 1'b0;
    check("R10 released", 64'(inv_valid_o), 64'd0);
    check("R10 ready", 64'(req_ready_o), 64'd1);
    look(32'hC0,  1'b0, 64'h0,  "R10 victim gone");
    look(32'h140, 1'b1, 64'h20, "R10 installed");
    look(32'h80,  1'b1, 64'h4,  "R10 B kept");
    look(32'h100, 1'b1, 64'h40, "R10 D kept");

    // touches: A(w0), E(w2 install), E, B(w1), D(w3) -> bit0=0, bit1=0 -> way 0
    do_req(2'd1, 32'h180, 6'd9, 6'd2);
    check("R9 second victim", 64'(inv_addr_o), 64'h40);
    check("R12 second vec", inv_vec_o, 64'h2);
    inv_ready_i = 1'b1;
    @(negedge clk_i);
    inv_ready_i = 1'b0;
    look(32'h180, 1'b1, 64'h200, "R10 second install");
    look(32'h40,  1'b0, 64'h0,   "R9 A evicted");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule